// File: doc/BRIEF.md
# GPIO Pin Interrupt Unit

This unit turns activity on the eight lowest pins of a GPIO bank into interrupt requests. Each pin is first brought into the clock domain by a short flip-flop chain. It can then pass through an optional stability filter before it reaches a per-pin detector. That detector either looks for transitions or watches for a steady level. Each detector hit latches a pending flag, and one combined interrupt line is high whenever any flag is pending.

Software drives the unit over the bank's 32-bit register bus. The 32-bit control word has no plain write address: ones written to one offset set control bits, and ones written to a second offset clear them. Reading the set offset returns the current word. Pending flags are read at their own offset and are acknowledged by writing ones to a separate offset.

A pin is in edge mode or level mode. In edge mode, its two enable bits choose the rising transition, the falling transition, or both. In level mode, the same two bits choose an active-high or an active-low condition. In level mode the flag is set again after an acknowledge for as long as the condition holds.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset the control word reads 0, all pending flags read 0 and `irq` is low.
- R2: Write semantics of the control word:
  - Writing at offset 0x18 ORs the write data into the control word, and reading at 0x18 returns the word.
  - Writing at 0x1C clears every bit that is 1 in the write data.
  - Field positions: rise enable [7:0], fall enable [15:8], filter enable [23:16], level mode [31:24]. Bit n of each field belongs to pin n.
- R3: With the level bit 0, a pin with rise enabled becomes pending after a 0→1 transition. A pin with fall enabled becomes pending after a 1→0 transition. With both enabled, either transition sets the flag.
- R4: With the level bit 1, the rise bit makes a high pin pending and the fall bit makes a low pin pending.
- R5: A pin with both rise and fall enable cleared never becomes pending, whatever its input does.
- R6: Reading offset 0x24 returns the pending flags in bits [7:0]; bits [31:8] always read 0. Writing ones at 0x20 clears the selected flags; zero bits leave their flags untouched.
- R7: A level-mode flag whose condition still holds is set again in the cycle after an acknowledge, so it stays pending.
- R8: With its filter bit set, a pin change reaches detection only after the synchronized input has held the new value for 16 consecutive clocks. Shorter pulses are dropped.
- R9: `irq` is high exactly when at least one pending flag is set.
- R10: Enabling a pin whose input is already steady never creates a pending flag by itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe, one write per cycle it is high |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Raw pin inputs, asynchronous |
| irq | output | 1 | Combined interrupt request |

## Verification
The random part runs many trials. Each trial draws a pin, a value before and a value after, and a mode from all eight combinations of rise, fall and level. The trials therefore separate transition detection from level detection, and rising from falling polarity, including the case where an active level before the change keeps the flag latched after it. Directed cases cover the rest:
- an acknowledge with the level condition still held, against one after the condition has gone;
- enabling a pin on an already-high or already-low input;
- a filtered pin given a short glitch and then a long hold, which tells the filter's drop window from its accept point;
- acknowledge writes with zero bits, set and clear writes on overlapping masks, and reads of the upper status bits.

// File: rtl/gpio_irq_pkg.sv
// Package: shared constants and the control word layout for the GPIO pin
// interrupt unit. Assumes a byte-addressed 32-bit register bus.
package gpio_irq_pkg;
    localparam int PINS   = 8;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 8;

    // Register offsets; software depends on these values.
    localparam logic [ADDR_W-1:0] OFS_CTRL_SET = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_CTRL_CLR = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_ACK      = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h24;

    // Control word; packed MSB first, so lvl sits in [31:24] and rise in [7:0].
    typedef struct packed {
        logic [PINS-1:0] lvl;
        logic [PINS-1:0] filt;
        logic [PINS-1:0] fall;
        logic [PINS-1:0] rise;
    } ctrl_t;
endpackage

// File: rtl/gpio_irq_sync.sv
// Module: multi-stage synchronizer for the raw pin inputs.
// Assumes the pins are asynchronous to clk; STAGES >= 2.
module gpio_irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);
    logic [WIDTH-1:0] stg [STAGES];

    // Shift the raw pins through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= raw;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign synced = stg[STAGES-1];
endmodule

// File: rtl/gpio_irq_filter.sv
// Module: per-pin stability filter. When a pin's enable is low, the output
// follows the input one cycle later. When it is high, the output takes a new
// value only after the input has differed from the output for HOLD
// consecutive clocks. Assumes HOLD >= 2.
module gpio_irq_filter #(
    parameter int WIDTH = 8,
    parameter int HOLD  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic [WIDTH-1:0] en,
    output logic [WIDTH-1:0] dout
);
    localparam int CNT_W = $clog2(HOLD);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HOLD - 1);

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic [CNT_W-1:0] cnt;

        // Count cycles of disagreement and accept the value after HOLD of them.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt     <= '0;
                dout[g] <= 1'b0;
            end else if (!en[g]) begin
                cnt     <= '0;
                dout[g] <= din[g];
            end else if (din[g] == dout[g]) begin
                cnt     <= '0;
            end else if (cnt == CNT_LAST) begin
                cnt     <= '0;
                dout[g] <= din[g];
            end else begin
                cnt     <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: per-pin trigger detector. It keeps the previous sample of every
// pin, so a change to the enables does not invent a transition. Hits are
// combinational from the current and previous samples.
module gpio_irq_detect #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] smp,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic [WIDTH-1:0] lvl_mode,
    output logic [WIDTH-1:0] hit
);
    logic [WIDTH-1:0] prev;

    // Track the previous sample on every cycle, whatever the enables are.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= smp;
    end

    for (genvar g = 0; g < WIDTH; g++) begin : g_pin
        logic up, down, hi_hit, lo_hit;

        // Decode this pin's trigger condition from its mode bits.
        always_comb begin
            up     = smp[g] & ~prev[g];
            down   = ~smp[g] & prev[g];
            hi_hit = rise_en[g] & (lvl_mode[g] ? smp[g]  : up);
            lo_hit = fall_en[g] & (lvl_mode[g] ? ~smp[g] : down);
            hit[g] = hi_hit | lo_hit;
        end
    end
endmodule

// File: rtl/gpio_irq_regs.sv
// Module: register file holding the set/clear control word and the pending
// flags, plus read decode and the combined request. A hit and an
// acknowledge of the same flag in one cycle leave the flag set.
module gpio_irq_regs
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   hit,
    output ctrl_t             ctrl,
    output logic [PINS-1:0]   pend,
    output logic              irq
);
    logic            wr_set, wr_clr, wr_ack;
    logic [PINS-1:0] ack_mask;

    // Decode the write strobes per offset.
    always_comb begin
        wr_set   = bus_we && (bus_addr == OFS_CTRL_SET);
        wr_clr   = bus_we && (bus_addr == OFS_CTRL_CLR);
        wr_ack   = bus_we && (bus_addr == OFS_ACK);
        ack_mask = wr_ack ? bus_wdata[PINS-1:0] : '0;
    end

    // Control word: ones set at one offset, ones clear at the other.
    always_ff @(posedge clk) begin
        if (!rst_n)      ctrl <= '0;
        else if (wr_set) ctrl <= ctrl | bus_wdata;
        else if (wr_clr) ctrl <= ctrl & ~bus_wdata;
    end

    // Pending flags: cleared by acknowledge, with new hits taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend & ~ack_mask) | hit;
    end

    // Read mux; only the low PINS status bits can ever be nonzero.
    always_comb begin
        case (bus_addr)
            OFS_CTRL_SET: bus_rdata = ctrl;
            OFS_STATUS:   bus_rdata = {{(BUS_W-PINS){1'b0}}, pend};
            default:      bus_rdata = '0;
        endcase
    end

    assign irq = |pend;
endmodule

// File: rtl/gpio_irq_unit.sv
// Module: top of the GPIO pin interrupt unit. The chain is
// synchronizer -> optional stability filter -> detector -> pending flags.
// Assumes a single clock and a synchronous active-low reset.
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_HOLD   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [PINS-1:0]   pin_in,
    output logic              irq
);
    ctrl_t           ctrl_w;
    logic [PINS-1:0] sync_w, filt_w, hit_w, pend_w;

    gpio_irq_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw(pin_in), .synced(sync_w)
    );

    gpio_irq_filter #(.WIDTH(PINS), .HOLD(FILT_HOLD)) filt_i (
        .clk(clk), .rst_n(rst_n), .din(sync_w), .en(ctrl_w.filt), .dout(filt_w)
    );

    gpio_irq_detect #(.WIDTH(PINS)) det_i (
        .clk(clk), .rst_n(rst_n), .smp(filt_w),
        .rise_en(ctrl_w.rise), .fall_en(ctrl_w.fall), .lvl_mode(ctrl_w.lvl),
        .hit(hit_w)
    );

    gpio_irq_regs regs_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hit(hit_w),
        .ctrl(ctrl_w), .pend(pend_w), .irq(irq)
    );
endmodule

// File: rtl/gpio_irq_unit_chk.sv
// Module: assertion checker for gpio_irq_unit, attached with bind below.
module gpio_irq_unit_chk
    import gpio_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BUS_W-1:0]  bus_wdata,
    input logic [BUS_W-1:0]  bus_rdata,
    input logic              irq,
    input logic [BUS_W-1:0]  ctrl,
    input logic [PINS-1:0]   pend,
    input logic [PINS-1:0]   hit
);
    AST_CTRL_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CTRL_SET) |=> ((ctrl & $past(bus_wdata)) == $past(bus_wdata))); // R2
    AST_CTRL_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CTRL_CLR) |=> ((ctrl & $past(bus_wdata)) == '0)); // R2
    AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((pend & $past(hit)) == $past(hit))); // R3
    AST_NO_SPURIOUS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend & ~$past(pend) & ~$past(hit)) == '0)); // R3
    AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (hit & ~(ctrl[PINS-1:0] | ctrl[2*PINS-1:PINS])) == '0); // R5
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_ACK) |=> ((pend & $past(bus_wdata[PINS-1:0]) & ~$past(hit)) == '0)); // R6
    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_STATUS) |-> (bus_rdata[BUS_W-1:PINS] == '0)); // R6
    AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(hit) != '0)); // R9
endmodule

bind gpio_irq_unit gpio_irq_unit_chk chk_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .ctrl(ctrl_w), .pend(pend_w), .hit(hit_w)
);

// File: tb/gpio_irq_unit_tb_top.sv
// Bench: directed corner cases plus seeded random trials for gpio_irq_unit.
module gpio_irq_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] A_SET = 8'h18, A_CLR = 8'h1C, A_ACK = 8'h20, A_STAT = 8'h24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic        irq;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_unit dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .irq(irq)
    );

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected flag of one pin from its mode and its values before and after.
    function automatic bit exp_pend(bit lvl, bit rise, bit fall, bit oldv, bit newv);
        if (lvl) return (rise && (oldv || newv)) || (fall && (!oldv || !newv));
        return (rise && !oldv && newv) || (fall && oldv && !newv);
    endfunction

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1: reset state
        rd(A_SET, d);  chk("R1 ctrl", d, 32'h0);
        rd(A_STAT, d); chk("R1 status", d, 32'h0);
        chk("R1 irq", {31'd0, irq}, 32'h0);

        // R2: set and clear semantics with field positions
        wr(A_SET, 32'h0000_00A5);
        rd(A_SET, d); chk("R2 set", d, 32'h0000_00A5);
        wr(A_SET, 32'hFF00_0000);
        rd(A_SET, d); chk("R2 set or", d, 32'hFF00_00A5);
        wr(A_CLR, 32'h0F00_0005);
        rd(A_SET, d); chk("R2 clear", d, 32'hF000_00A0);
        wr(A_CLR, 32'hFFFF_FFFF);
        rd(A_SET, d); chk("R2 clear all", d, 32'h0);

        // R10: enabling on a steady input gives no flag
        pin_in[6] = 1'b1; idle(8);
        wr(A_SET, 32'h0000_0040);
        wr(A_SET, 32'h0000_0200);
        idle(8);
        rd(A_STAT, d); chk("R10 no false edge", d, 32'h0);

        // R3: rising edge on pin 6, then R6 zero-ack keeps it, ones-ack clears
        pin_in[1] = 1'b1; idle(8);
        rd(A_STAT, d); chk("R10 fall on high-steady pin1", d, 32'h0);
        pin_in[6] = 1'b0; idle(8);
        rd(A_STAT, d); chk("R3 fall not enabled pin6", d, 32'h0);
        pin_in[6] = 1'b1; idle(8);
        rd(A_STAT, d); chk("R3 rise pin6", d, 32'h40);
        chk("R9 irq high", {31'd0, irq}, 32'h1);
        wr(A_ACK, 32'h0000_0000);
        rd(A_STAT, d); chk("R6 zero ack keeps", d, 32'h40);
        wr(A_ACK, 32'hFFFF_FFFF);
        idle(2);
        rd(A_STAT, d); chk("R6 ack clears, upper zero", d, 32'h0);
        chk("R9 irq low", {31'd0, irq}, 32'h0);
        pin_in[1] = 1'b0; idle(8);
        rd(A_STAT, d); chk("R3 fall pin1", d, 32'h02);
        wr(A_CLR, 32'hFFFF_FFFF); wr(A_ACK, 32'hFF);

        // R7 and R4: level-high flag survives ack while the pin stays high
        pin_in[5] = 1'b1; idle(8);
        wr(A_SET, 32'h2000_0020);
        idle(6);
        rd(A_STAT, d); chk("R4 level high", d, 32'h20);
        wr(A_ACK, 32'h20); idle(2);
        rd(A_STAT, d); chk("R7 repend after ack", d, 32'h20);
        pin_in[5] = 1'b0; idle(8);
        wr(A_ACK, 32'h20); idle(3);
        rd(A_STAT, d); chk("R7 ack after release", d, 32'h0);
        // R4: level low on the same pin
        wr(A_CLR, 32'h0000_0020); wr(A_SET, 32'h0000_2000);
        idle(4);
        rd(A_STAT, d); chk("R4 level low", d, 32'h20);
        // R5: masked pin ignores toggles
        wr(A_CLR, 32'hFFFF_FFFF); wr(A_ACK, 32'hFF);
        for (int k = 0; k < 6; k++) begin pin_in[5] = ~pin_in[5]; idle(6); end
        rd(A_STAT, d); chk("R5 masked", d, 32'h0);

        // R8: filtered pin 3 drops a short glitch and accepts a long hold
        pin_in[3] = 1'b0; idle(8);
        wr(A_SET, 32'h0008_0008); wr(A_ACK, 32'hFF);
        pin_in[3] = 1'b1; idle(8); pin_in[3] = 1'b0; idle(30);
        rd(A_STAT, d); chk("R8 glitch dropped", d, 32'h0);
        pin_in[3] = 1'b1; idle(10);
        rd(A_STAT, d); chk("R8 not yet stable", d, 32'h0);
        idle(20);
        rd(A_STAT, d); chk("R8 long hold accepted", d, 32'h08);
        wr(A_CLR, 32'hFFFF_FFFF); wr(A_ACK, 32'hFF);

        // R3 R4 R9: random trials over mode, pin and values
        for (int t = 0; t < 60; t++) begin
            int unsigned p = $urandom % 8;
            bit oldv = 1'($urandom), newv = 1'($urandom);
            bit rise = 1'($urandom), fall = 1'($urandom), lvl = 1'($urandom);
            bit e;
            logic [31:0] cfg;
            pin_in[p] = oldv; idle(8);
            wr(A_CLR, 32'hFFFF_FFFF);
            cfg = (32'(rise) << p) | (32'(fall) << (p + 8)) | (32'(lvl) << (p + 24));
            wr(A_SET, cfg);
            wr(A_ACK, 32'hFF); idle(8);
            if (!lvl) wr(A_ACK, 32'hFF);
            pin_in[p] = newv; idle(8);
            e = exp_pend(lvl, rise, fall, oldv, newv);
            rd(A_STAT, d); chk(lvl ? "R4 random" : "R3 random", d, 32'(e) << p);
            chk("R9 random irq", {31'd0, irq}, {31'd0, e});
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule